// File: doc/BRIEF.md
# UART Transmit Queue with Low-Water Interrupt and Half-Duplex Direction Control

This block is the transmit side of a serial port, minus the bit shifter. The host pushes bytes into a small queue. The queue hands them to an external shifter through a valid/take handshake, and the shifter reports back when the last stop bit of each byte has left the line. The block raises a level-sensitive transmit interrupt. With a zero threshold the interrupt waits until everything queued has been sent. With a nonzero threshold it fires as soon as the queue has drained to that depth, so the host can top the queue up before it runs dry.

For two-wire half-duplex links, an auto-direction mode drives a request-to-send line that enables the line driver. The line goes high on the first write into an idle transmitter, and bytes are offered to the shifter only after one bit-time of lead. The line stays high until the queue is empty and the shifter has signalled that the final stop bit is out. A pacing mode limits the queue to a single byte so that the host loads one byte per interrupt when feeding slow receivers. Writes that find the queue full are discarded and recorded in a sticky overflow flag.

Top module: `uart_tx_lowwater`

## Requirements
- R1: Bytes reach `ser_data` in write order. A byte is consumed only when `ser_take` is high while `ser_valid` is high, and `ser_data` holds its value while `ser_valid` is high and no take occurs.
- R2: `fifo_count` rises by one for each accepted write and falls by one for each take. A write and a take in the same cycle leave it unchanged.
- R3: When `low_water` is 0 or `pace` is 1, `tx_irq` is high only when `fifo_count` is 0 and no byte is still in the shifter. A byte counts as in the shifter from its take until the next `ser_done` pulse.
- R4: When `low_water` is nonzero and `pace` is 0, `tx_irq` is high exactly while `fifo_count` is less than or equal to `low_water`. It drops once writes raise the count above that level.
- R5: A write while the queue is full is dropped, even if a take happens in the same cycle, and it sets `tx_ovf`. `tx_ovf` then stays high until reset, and `fifo_count` never exceeds DEPTH.
- R6: With `pace` high, the queue holds at most one byte, and a write that finds one byte queued counts as a write into a full queue.
- R7: With `auto_dir` high, an accepted write into an idle transmitter raises `rts` at the next clock edge. `ser_valid` first rises exactly BIT_CYCLES clock cycles after `rts` rises, and `ser_valid` is never high while `rts` is low.
- R8: With `auto_dir` high, `rts` falls at the clock edge that samples a `ser_done` pulse while the queue is empty and no write or take occurs. It stays high in every other case.
- R9: With `auto_dir` low, `rts` stays low and `ser_valid` is high whenever `fifo_count` is nonzero.
- R10: After reset, `fifo_count` is 0, `ser_valid`, `rts` and `tx_ovf` are low, and `tx_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write byte |
| ser_take | input | 1 | Shifter accepts `ser_data` this cycle |
| ser_done | input | 1 | Shifter has sent the last stop bit of its byte |
| low_water | input | CW | Interrupt threshold; 0 means interrupt only when fully sent |
| auto_dir | input | 1 | Enables automatic half-duplex direction control on `rts` |
| pace | input | 1 | One-byte pacing mode |
| ser_data | output | DATA_W | Byte at the head of the queue |
| ser_valid | output | 1 | Head byte may be taken by the shifter |
| tx_irq | output | 1 | Level-sensitive transmit interrupt |
| fifo_count | output | CW | Number of queued bytes |
| rts | output | 1 | Line-driver enable for half-duplex operation |
| tx_ovf | output | 1 | Sticky flag for a write dropped on a full queue |

## Verification
On every cycle, the assertions check that the head byte holds steady until it is taken, that the count moves by at most one, and that the count never goes past its bound. They also check that the overflow flag is sticky, that the interrupt never stays high above the threshold or before the queue is empty in drained mode, and that no byte is offered while the driver is disabled. The only other things they check per cycle are that the driver enable falls only after a completion pulse on an empty queue, and that pacing caps the queue at one byte. Only the bench's scenarios can show the exact one-bit-time lead between the driver enable and the first offered byte, the full write order of the data, and the interrupt rising at the threshold crossing while a byte is still being shifted. The same holds for the enable falling in the very cycle after the last completion pulse.

// File: rtl/uart_tx_lw_pkg.sv
package uart_tx_lw_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_LEAD = 2'd1,
    DIR_LIVE = 2'd2
  } dir_state_e;
endpackage

// File: rtl/uart_tx_lw_fifo.sv
module uart_tx_lw_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    case ({push, pop})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/uart_tx_lw_dir.sv
module uart_tx_lw_dir
  import uart_tx_lw_pkg::*;
#(
  parameter int BIT_CYCLES = 16,
  parameter int CW         = 5,
  localparam int LCW       = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_dir,
  input  logic          push,
  input  logic          pop,
  input  logic          ser_done,
  input  logic [CW-1:0] count,
  output logic          rts,
  output logic          tx_en,
  output logic          shift_busy
);
  dir_state_e st_q, st_d;
  logic [LCW-1:0] lead_q, lead_d;
  logic busy_q, busy_d;

  always_comb begin
    st_d   = st_q;
    lead_d = lead_q;
    if (!auto_dir) begin
      st_d = DIR_IDLE;
    end else begin
      case (st_q)
        DIR_IDLE: if (push) begin
          st_d   = DIR_LEAD;
          lead_d = LCW'(BIT_CYCLES - 1);
        end
        DIR_LEAD: if (lead_q == '0) st_d = DIR_LIVE;
                  else lead_d = lead_q - LCW'(1);
        DIR_LIVE: if (ser_done && !pop && !push && count == '0) st_d = DIR_IDLE;
        default:  st_d = DIR_IDLE;
      endcase
    end
    if (pop)           busy_d = 1'b1;
    else if (ser_done) busy_d = 1'b0;
    else               busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DIR_IDLE;
      lead_q <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lead_q <= lead_d;
      busy_q <= busy_d;
    end
  end

  assign rts        = auto_dir && (st_q != DIR_IDLE);
  assign tx_en      = !auto_dir || (st_q == DIR_LIVE);
  assign shift_busy = busy_q;
endmodule

// File: rtl/uart_tx_lw_flags.sv
module uart_tx_lw_flags #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          pace,
  input  logic [CW-1:0] low_water,
  input  logic [CW-1:0] count,
  input  logic          shift_busy,
  output logic          push,
  output logic          irq,
  output logic          ovf
);
  logic full;
  logic ovf_q, ovf_d;
  logic drained_mode;

  always_comb begin
    full         = pace ? (count != '0) : (count == CW'(DEPTH));
    push         = wr_en && !full;
    ovf_d        = ovf_q || (wr_en && full);
    drained_mode = pace || (low_water == '0);
    irq          = drained_mode ? ((count == '0) && !shift_busy)
                                : (count <= low_water);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/uart_tx_lowwater.sv
module uart_tx_lowwater #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int BIT_CYCLES = 16,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ser_take,
  input  logic              ser_done,
  input  logic [CW-1:0]     low_water,
  input  logic              auto_dir,
  input  logic              pace,
  output logic [DATA_W-1:0] ser_data,
  output logic              ser_valid,
  output logic              tx_irq,
  output logic [CW-1:0]     fifo_count,
  output logic              rts,
  output logic              tx_ovf
);
  logic push, pop, tx_en, shift_busy;
  logic [CW-1:0] count;

  assign ser_valid  = tx_en && (count != '0);
  assign pop        = ser_take && ser_valid;
  assign fifo_count = count;

  uart_tx_lw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata(wr_data), .rdata(ser_data), .count(count)
  );

  uart_tx_lw_dir #(.BIT_CYCLES(BIT_CYCLES), .CW(CW)) u_dir (
    .clk(clk), .rst_n(rst_n), .auto_dir(auto_dir), .push(push), .pop(pop),
    .ser_done(ser_done), .count(count), .rts(rts), .tx_en(tx_en),
    .shift_busy(shift_busy)
  );

  uart_tx_lw_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pace(pace),
    .low_water(low_water), .count(count), .shift_busy(shift_busy),
    .push(push), .irq(tx_irq), .ovf(tx_ovf)
  );
endmodule

// File: rtl/uart_tx_lowwater_chk.sv
module uart_tx_lowwater_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              ser_take,
  input logic              ser_done,
  input logic [CW-1:0]     low_water,
  input logic              auto_dir,
  input logic              pace,
  input logic [DATA_W-1:0] ser_data,
  input logic              ser_valid,
  input logic              tx_irq,
  input logic [CW-1:0]     fifo_count,
  input logic              rts,
  input logic              tx_ovf
);
  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_take |=> $stable(ser_data)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == $past(fifo_count)) || (fifo_count == $past(fifo_count) + CW'(1))
    || (fifo_count + CW'(1) == $past(fifo_count))); // R2
  AST_IRQ_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && (pace || low_water == '0) |-> fifo_count == '0); // R3
  AST_IRQ_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pace && low_water != '0 && fifo_count > low_water |-> !tx_irq); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH)); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && fifo_count == CW'(DEPTH) |=> tx_ovf); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R5
  AST_PACE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pace && fifo_count <= CW'(1) |=> pace |-> fifo_count <= CW'(1)); // R6
  AST_RTS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir && ser_valid |-> rts); // R7
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) && auto_dir && $past(auto_dir) |-> $past(ser_done) && fifo_count == '0); // R8
endmodule

bind uart_tx_lowwater uart_tx_lowwater_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ser_take(ser_take),
  .ser_done(ser_done), .low_water(low_water), .auto_dir(auto_dir),
  .pace(pace), .ser_data(ser_data), .ser_valid(ser_valid), .tx_irq(tx_irq),
  .fifo_count(fifo_count), .rts(rts), .tx_ovf(tx_ovf)
);

// File: tb/uart_tx_lowwater_bench.sv
`timescale 1ns/100ps
module uart_tx_lowwater_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int BITC   = 16;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int SHIFT  = 6;

  logic clk = 1'b0;
  logic rst_n, wr_en, ser_take, ser_done, auto_dir, pace;
  logic [DATA_W-1:0] wr_data, ser_data;
  logic [CW-1:0] low_water, fifo_count;
  logic ser_valid, tx_irq, rts, tx_ovf;

  int checks = 0, errors = 0, cyc = 0, last_done_cyc = -100;
  bit sink_en, sh_busy;
  int sh_cnt;

  always #2.5 clk = ~clk;

  uart_tx_lowwater #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BIT_CYCLES(BITC)) u_uart_tx_lowwater (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ser_take(ser_take), .ser_done(ser_done), .low_water(low_water),
    .auto_dir(auto_dir), .pace(pace), .ser_data(ser_data),
    .ser_valid(ser_valid), .tx_irq(tx_irq), .fifo_count(fifo_count),
    .rts(rts), .tx_ovf(tx_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: byte queue, shifter flag, direction phase, lead counter.
  int q[$];
  bit m_busy, m_ovf, m_push, m_pop, m_valid;
  int m_phase, m_lead, m_cap, m_old;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_ovf = 0; m_phase = 0; m_lead = 0;
    end else begin
      m_cap   = pace ? 1 : DEPTH;
      m_old   = q.size();
      m_push  = wr_en && (m_old < m_cap);
      if (wr_en && !(m_old < m_cap)) m_ovf = 1;
      m_valid = (!auto_dir || m_phase == 2) && m_old > 0;
      m_pop   = ser_take && m_valid;
      if (m_pop) void'(q.pop_front());
      if (m_push) q.push_back(int'(wr_data));
      if (m_pop) m_busy = 1; else if (ser_done) m_busy = 0;
      if (!auto_dir) m_phase = 0;
      else if (m_phase == 0) begin
        if (m_push) begin m_phase = 1; m_lead = BITC - 1; end
      end else if (m_phase == 1) begin
        if (m_lead == 0) m_phase = 2; else m_lead--;
      end else if (ser_done && !m_pop && !m_push && m_old == 0) m_phase = 0;
    end
    #1;
    if (rst_n) begin
      m_valid = (!auto_dir || m_phase == 2) && q.size() > 0;
      chk("R1", "ser_valid", int'(ser_valid), int'(m_valid));
      if (m_valid) chk("R1", "ser_data", int'(ser_data), q[0]);
      chk("R2", "fifo_count", int'(fifo_count), q.size());
      if (pace || low_water == 0)
        chk("R3", "tx_irq", int'(tx_irq), int'(q.size() == 0 && !m_busy));
      else
        chk("R4", "tx_irq", int'(tx_irq), int'(q.size() <= int'(low_water)));
      chk("R5", "tx_ovf", int'(tx_ovf), int'(m_ovf));
      chk("R8", "rts", int'(rts), int'(auto_dir && m_phase != 0));
    end
  end

  // Shifter model: takes a byte when allowed, reports completion SHIFT cycles later.
  always @(negedge clk) begin
    ser_take = 1'b0;
    ser_done = 1'b0;
    if (!rst_n) begin
      sh_busy = 0; sh_cnt = 0;
    end else if (sh_busy) begin
      if (sh_cnt == 0) begin ser_done = 1'b1; sh_busy = 0; last_done_cyc = cyc; end
      else sh_cnt--;
    end else if (sink_en && ser_valid) begin
      ser_take = 1'b1; sh_busy = 1; sh_cnt = SHIFT;
    end
  end

  int seed = 8'h5a;
  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1;
      seed = (seed * 37 + 11) % 256;
      wr_data = DATA_W'(seed);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && fifo_count != 0; i++) @(negedge clk);
    repeat (SHIFT + 4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, c;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; low_water = '0;
    auto_dir = 1'b0; pace = 1'b0; sink_en = 1'b1;
    ser_take = 1'b0; ser_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "reset count", int'(fifo_count), 0);
    chk("R10", "reset valid", int'(ser_valid), 0);
    chk("R10", "reset rts", int'(rts), 0);
    chk("R10", "reset irq", int'(tx_irq), 1);
    chk("R10", "reset ovf", int'(tx_ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: manual direction, plain drain
    burst(3);
    chk("R9", "rts manual", int'(rts), 0);
    drain();
    chk("R9", "rts after drain", int'(rts), 0);
    chk("R3", "irq when sent", int'(tx_irq), 1);

    // R3: queue empty but last byte still shifting
    burst(2);
    for (int i = 0; i < 200 && fifo_count != 0; i++) @(negedge clk);
    chk("R3", "irq while shifting", int'(tx_irq), 0);
    drain();
    chk("R3", "irq after done", int'(tx_irq), 1);

    // R4: nonzero low-water level
    low_water = CW'(4); sink_en = 0;
    burst(6);
    chk("R4", "irq above level", int'(tx_irq), 0);
    sink_en = 1;
    for (int i = 0; i < 500 && fifo_count != 4; i++) @(negedge clk);
    chk("R4", "irq at level", int'(tx_irq), 1);
    chk("R4", "count at level", int'(fifo_count), 4);
    sink_en = 0;
    repeat (SHIFT + 4) @(negedge clk);
    c = int'(fifo_count);
    burst(5 - c);
    chk("R4", "count after refill", int'(fifo_count), 5);
    chk("R4", "irq after refill", int'(tx_irq), 0);
    sink_en = 1;
    drain();
    low_water = '0;

    // R5: overflow
    sink_en = 0;
    repeat (SHIFT + 4) @(negedge clk);
    burst(DEPTH + 2);
    chk("R5", "count full", int'(fifo_count), DEPTH);
    chk("R5", "ovf set", int'(tx_ovf), 1);
    sink_en = 1;
    drain();
    chk("R5", "ovf sticky", int'(tx_ovf), 1);

    // R6: pacing mode
    pace = 1; sink_en = 0;
    burst(2);
    chk("R6", "pace cap", int'(fifo_count), 1);
    sink_en = 1;
    drain();
    chk("R6", "pace irq", int'(tx_irq), 1);
    pace = 0;

    // R7 / R8: automatic direction control
    auto_dir = 1;
    repeat (3) @(negedge clk);
    chk("R7", "rts idle", int'(rts), 0);
    burst(1);
    chk("R7", "rts on first write", int'(rts), 1);
    chk("R7", "no byte in lead", int'(ser_valid), 0);
    t0 = cyc;
    burst(2);
    for (int i = 0; i < 200 && !ser_valid; i++) @(negedge clk);
    chk("R7", "lead cycles", cyc - t0, BITC);
    for (int i = 0; i < 2000 && rts; i++) @(negedge clk);
    chk("R8", "count at release", int'(fifo_count), 0);
    chk("R8", "release after done", last_done_cyc, cyc - 1);
    repeat (4) @(negedge clk);
    chk("R8", "rts stays low", int'(rts), 0);
    auto_dir = 0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule